// File: doc/BRIEF.md
# Tick-Driven PWM Channel with Repeat-Limited Burst

This block produces one pulse-width-modulated output from a counter that advances only on clock cycles where a count-enable tick is high. Software programs it through a small write port that selects one of four words: a period, a duty threshold and a control word. The word at select 0 is the live counter and cannot be written. The control word turns the channel on. It picks a mode: a burst of a set number of periods, free-running, or pulse-width capture. It also sets the level driven during the duty portion, the level driven when the channel is not generating, and whether pulses are edge- or centre-aligned.

Period and duty are written into holding registers. The running sequence takes copies of them when it starts and again at each period boundary, so a waveform never mixes old and new settings. In burst mode the channel runs one more period than the repeat field states. It then clears its own enable bit, falls back to the idle level and raises a done flag. In capture mode the counter measures how many ticks the capture pin stays high.

The sequencer has five states. OFF is the idle state. EDGE counts a left-aligned period. FALL and RISE are the two halves of a centre-aligned period. CAPT measures pulses. The transitions are:
- OFF to CAPT when the enable bit is set and the mode is capture.
- OFF to FALL when the enable bit is set in a generating mode with centre alignment.
- OFF to EDGE when the enable bit is set in a generating mode without centre alignment.
- FALL to RISE on a tick while the counter is 0.
- RISE to FALL on a tick that ends a period.
- EDGE or RISE to OFF on the tick that ends the last period of a burst.
- Any state to OFF once the enable bit is clear.

Top module: `pwm_channel`

## Requirements
- R1: After reset the counter reads 0, done is low, and the output is low, because the idle level bit resets to 0.
- R2: A write with select 1 loads the period and select 2 loads the duty. Select 3 loads the control word: bit 0 enable, bits [2:1] mode (00 burst, 01 free-running, 10 capture, 11 behaves as free-running), bit 3 active level, bit 4 idle level, bit 5 centre alignment, bits [31:24] repeat count. A write with select 0 has no effect.
- R3: The channel starts on the clock edge after the one that stores a set enable bit. While generating, the counter changes only on cycles with the tick high.
- R4: With left alignment the counter steps 0, 1, ... P-1 and wraps to 0. The output is at the active level while the counter is below the duty value D.
- R5: With centre alignment the counter starts at P-1 and steps down to 0. It stays at 0 for one more tick while turning, then steps up to P-1, and the next tick starts a new period at P-1. One period is 2P ticks with 2D contiguous active ticks in its middle.
- R6: The active level equals control bit 3 and the rest of the period drives its complement. Whenever the channel is not generating, the output equals control bit 4.
- R7: Period and duty writes made while the channel is generating take effect only at the next period boundary.
- R8: In burst mode the channel runs repeat+1 periods. On the tick that ends the last one, the counter goes to 0, the enable bit clears, the output goes to the idle level and done rises. Done stays high until the channel next starts.
- R9: In capture mode a rising capture pin resets the counter, and that cycle counts as 1 if the tick is high. Each later cycle with both the pin and the tick high adds one, up to the counter's maximum. The count holds while the pin is low, and the output stays at the idle level.
- R10: Once a control write clears the enable bit, the next clock edge puts the channel in OFF with the counter at 0.
- R11: A duty value at or above the period keeps the output at the active level for the whole period. A period of 0 behaves as a period of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for the counter |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Word select for the write |
| wr_data | input | 32 | Write data |
| cap_in | input | 1 | Capture input pin |
| pwm_out | output | 1 | PWM output pin |
| cnt_out | output | CW | Live counter value |
| done | output | 1 | Burst finished |

## Verification
A wrong state or counter in this block shows up on the output pin and the counter port at the next tick. The most that can stay hidden is one tick: a centre-aligned sequence that turns a step early or late moves the active pulse, and the counter port shows the error on that same tick. A burst that counts its repeat field wrongly moves the rise of done by whole periods, so the done flag is checked after every tick. Settings taken on too early show up as a period length that changes part-way through a period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [2:0] {
        S_OFF  = 3'd0,
        S_EDGE = 3'd1,
        S_FALL = 3'd2,
        S_RISE = 3'd3,
        S_CAPT = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        M_BURST = 2'b00,
        M_FREE  = 2'b01,
        M_CAPT  = 2'b10,
        M_SPARE = 2'b11
    } mode_e;

    localparam logic [1:0] SEL_COUNT  = 2'd0;
    localparam logic [1:0] SEL_PERIOD = 2'd1;
    localparam logic [1:0] SEL_DUTY   = 2'd2;
    localparam logic [1:0] SEL_CTRL   = 2'd3;

    localparam int REP_W = 8;

    typedef struct packed {
        logic [REP_W-1:0] rep;
        logic             center;
        logic             idle_hi;
        logic             act_hi;
        mode_e            mode;
        logic             en;
    } ctl_t;

    function automatic ctl_t unpack_ctl(input logic [31:0] w);
        ctl_t c;
        c.en      = w[0];
        c.mode    = mode_e'(w[2:1]);
        c.act_hi  = w[3];
        c.idle_hi = w[4];
        c.center  = w[5];
        c.rep     = w[31:24];
        return c;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [31:0]   wr_data,
    input  logic          clr_en,
    output logic [CW-1:0] per_sh,
    output logic [CW-1:0] duty_sh,
    output ctl_t          ctl
);

    logic hit_per, hit_duty, hit_ctl;
    logic unused_hi;

    assign hit_per   = wr_en && (wr_sel == SEL_PERIOD);
    assign hit_duty  = wr_en && (wr_sel == SEL_DUTY);
    assign hit_ctl   = wr_en && (wr_sel == SEL_CTRL);
    assign unused_hi = ^wr_data[23:6];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_sh  <= '0;
            duty_sh <= '0;
        end else begin
            if (hit_per)  per_sh  <= wr_data[CW-1:0];
            if (hit_duty) duty_sh <= wr_data[CW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (hit_ctl) begin
            ctl <= unpack_ctl(wr_data);
        end else if (clr_en) begin
            ctl.en <= 1'b0;
        end
    end

endmodule

// File: rtl/pwm_seq.sv
module pwm_seq
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cap_in,
    input  logic             en,
    input  mode_e            mode,
    input  logic             center,
    input  logic [REP_W-1:0] rep,
    input  logic [CW-1:0]    per_sh,
    input  logic [CW-1:0]    duty_sh,
    output phase_e           phase,
    output logic [CW-1:0]    cnt,
    output logic [CW-1:0]    per_act,
    output logic [CW-1:0]    duty_act,
    output logic             done,
    output logic             clr_en
);

    localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};
    localparam logic [CW-1:0] CMAX = '1;

    phase_e           nxt_phase;
    logic [REP_W-1:0] rep_left;
    logic             one_lat;
    logic             cap_q;
    logic [CW-1:0]    lp;
    logic             last_step;
    logic             bound;
    logic             stop;
    logic             cap_rise;

    assign lp        = (per_sh == '0) ? ONE : per_sh;
    assign last_step = (cnt == per_act - ONE);
    assign bound     = tick && last_step && ((phase == S_EDGE) || (phase == S_RISE));
    assign stop      = bound && one_lat && (rep_left == '0);
    assign cap_rise  = cap_in && !cap_q;

    // next-state logic
    always_comb begin
        nxt_phase = phase;
        unique case (phase)
            S_OFF: begin
                if (en) begin
                    if (mode == M_CAPT) nxt_phase = S_CAPT;
                    else if (center)    nxt_phase = S_FALL;
                    else                nxt_phase = S_EDGE;
                end
            end
            S_EDGE: begin
                if (!en || stop) nxt_phase = S_OFF;
            end
            S_FALL: begin
                if (!en)                      nxt_phase = S_OFF;
                else if (tick && cnt == '0)   nxt_phase = S_RISE;
            end
            S_RISE: begin
                if (!en || stop) nxt_phase = S_OFF;
                else if (bound)  nxt_phase = S_FALL;
            end
            S_CAPT: begin
                if (!en) nxt_phase = S_OFF;
            end
            default: nxt_phase = S_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= S_OFF;
        else        phase <= nxt_phase;
    end

    // counter and per-period copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            per_act  <= ONE;
            duty_act <= '0;
            rep_left <= '0;
            one_lat  <= 1'b0;
            done     <= 1'b0;
            cap_q    <= 1'b0;
        end else begin
            cap_q <= cap_in;
            unique case (phase)
                S_OFF: begin
                    if (en) begin
                        done     <= 1'b0;
                        per_act  <= lp;
                        duty_act <= duty_sh;
                        rep_left <= rep;
                        one_lat  <= (mode == M_BURST);
                        cnt      <= (mode != M_CAPT && center) ? lp - ONE : '0;
                    end
                end
                S_EDGE, S_FALL, S_RISE: begin
                    if (!en) begin
                        cnt <= '0;
                    end else if (stop) begin
                        cnt  <= '0;
                        done <= 1'b1;
                    end else if (bound) begin
                        per_act  <= lp;
                        duty_act <= duty_sh;
                        if (one_lat) rep_left <= rep_left - 1'b1;
                        cnt <= (phase == S_RISE) ? lp - ONE : '0;
                    end else if (tick) begin
                        if (phase == S_FALL) begin
                            if (cnt != '0) cnt <= cnt - ONE;
                        end else begin
                            cnt <= cnt + ONE;
                        end
                    end
                end
                S_CAPT: begin
                    if (!en)                                 cnt <= '0;
                    else if (cap_rise)                       cnt <= tick ? ONE : '0;
                    else if (cap_in && tick && cnt != CMAX)  cnt <= cnt + ONE;
                end
                default: cnt <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        clr_en = stop;
    end

endmodule

// File: rtl/pwm_drive.sv
module pwm_drive
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  phase_e        phase,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] duty_act,
    input  logic          act_hi,
    input  logic          idle_hi,
    output logic          pwm
);

    logic gen;

    always_comb begin
        gen = (phase == S_EDGE) || (phase == S_FALL) || (phase == S_RISE);
        if (!gen)                pwm = idle_hi;
        else if (cnt < duty_act) pwm = act_hi;
        else                     pwm = !act_hi;
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [31:0]   wr_data,
    input  logic          cap_in,
    output logic          pwm_out,
    output logic [CW-1:0] cnt_out,
    output logic          done
);

    ctl_t          ctl;
    logic [CW-1:0] per_sh, duty_sh, per_act, duty_act;
    phase_e        phase;
    logic          clr_en;
    logic          en_w, idle_w;

    assign en_w   = ctl.en;
    assign idle_w = ctl.idle_hi;

    pwm_regs #(.CW(CW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .clr_en  (clr_en),
        .per_sh  (per_sh),
        .duty_sh (duty_sh),
        .ctl     (ctl)
    );

    pwm_seq #(.CW(CW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cap_in   (cap_in),
        .en       (ctl.en),
        .mode     (ctl.mode),
        .center   (ctl.center),
        .rep      (ctl.rep),
        .per_sh   (per_sh),
        .duty_sh  (duty_sh),
        .phase    (phase),
        .cnt      (cnt_out),
        .per_act  (per_act),
        .duty_act (duty_act),
        .done     (done),
        .clr_en   (clr_en)
    );

    pwm_drive #(.CW(CW)) u_drive (
        .phase    (phase),
        .cnt      (cnt_out),
        .duty_act (duty_act),
        .act_hi   (ctl.act_hi),
        .idle_hi  (ctl.idle_hi),
        .pwm      (pwm_out)
    );

endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          wr_en,
    input phase_e        phase,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] per_act,
    input logic          done,
    input logic          pwm_out,
    input logic          idle_hi,
    input logic          en
);

    logic gen;
    assign gen = (phase == S_EDGE) || (phase == S_FALL) || (phase == S_RISE);

    // R3: no tick, no write, still enabled -> counter holds
    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (gen && en && !tick && !wr_en) |=> (cnt == $past(cnt)));

    // R4 and R5: counter never reaches the active period
    a_r4_cnt_below_period: assert property (@(posedge clk) disable iff (!rst_n)
        gen |-> (cnt < per_act));

    // R6: idle level whenever off
    a_r6_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == S_OFF) |-> (pwm_out == idle_hi));

    // R8: done only while stopped
    a_r8_done_only_off: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase == S_OFF));

    // R9: capture keeps the idle level
    a_r9_capture_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == S_CAPT) |-> (pwm_out == idle_hi));

    // R10: cleared enable leads to OFF on the next edge
    a_r10_stop_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (phase == S_OFF));

endmodule

bind pwm_channel pwm_channel_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .phase   (phase),
    .cnt     (cnt_out),
    .per_act (per_act),
    .done    (done),
    .pwm_out (pwm_out),
    .idle_hi (idle_w),
    .en      (en_w)
);

// File: tb/tb_pwm_channel.sv
module tb_pwm_channel;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [31:0]   wr_data = '0;
    logic          cap_in = 1'b0;
    logic          pwm_out;
    logic [CW-1:0] cnt_out;
    logic          done;

    int checks = 0;
    int errors = 0;

    // bench copies of written settings
    int sh_per = 0, sh_duty = 0;
    bit c_en, c_act, c_idle, c_ctr;
    int c_mode, c_rep;
    // bench expectation of the sequence
    bit m_run, m_up, m_center, m_one, m_done;
    int m_cnt, m_per, m_duty, m_rep;

    always #4 clk = ~clk;

    pwm_channel #(.CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cap_in(cap_in), .pwm_out(pwm_out), .cnt_out(cnt_out),
        .done(done)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit en, int mode, bit act, bit idle, bit ctr, int rep);
        return {rep[7:0], 18'd0, ctr, idle, act, mode[1:0], en};
    endfunction

    task automatic wr(logic [1:0] sel, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel == 2'd1) sh_per = int'(d[15:0]);
        if (sel == 2'd2) sh_duty = int'(d[15:0]);
        if (sel == 2'd3) begin
            c_en = d[0]; c_mode = int'(d[2:1]); c_act = d[3];
            c_idle = d[4]; c_ctr = d[5]; c_rep = int'(d[31:24]);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int lp();
        return (sh_per == 0) ? 1 : sh_per;
    endfunction

    task automatic m_start();
        m_run = 1; m_done = 0;
        m_center = c_ctr; m_one = (c_mode == 0);
        m_per = lp(); m_duty = sh_duty; m_rep = c_rep;
        m_cnt = m_center ? m_per - 1 : 0;
        m_up = !m_center;
    endtask

    task automatic m_bound();
        if (m_one && m_rep == 0) begin
            m_run = 0; m_done = 1; m_cnt = 0; c_en = 0;
        end else begin
            if (m_one) m_rep--;
            m_per = lp(); m_duty = sh_duty;
            m_cnt = m_center ? m_per - 1 : 0;
            m_up = !m_center;
        end
    endtask

    task automatic m_tick();
        if (!m_run) return;
        if (m_center && !m_up) begin
            if (m_cnt == 0) m_up = 1;
            else m_cnt--;
        end else if (m_cnt == m_per - 1) begin
            m_bound();
        end else begin
            m_cnt++;
        end
    endtask

    task automatic cmp(string req);
        bit exp_pwm;
        exp_pwm = m_run ? ((m_cnt < m_duty) ? c_act : !c_act) : c_idle;
        chk({req, " cnt"}, 32'(cnt_out), 32'(m_cnt));
        chk({req, " pwm"}, 32'(pwm_out), 32'(exp_pwm));
        chk({req, " done"}, 32'(done), 32'(m_done));
    endtask

    task automatic step(string req);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        m_tick();
        cmp(req);
    endtask

    task automatic start();
        idle(1);
        m_start();
    endtask

    task automatic stop_ch(bit idle_lvl);
        wr(2'd3, mk(0, 1, 0, idle_lvl, 0, 0));
        idle(1);
        m_run = 0; m_cnt = 0;
    endtask

    // R1, R2: reset state and ignored counter write
    task automatic t_reset();
        idle(3);
        rst_n = 1'b1;
        idle(1);
        m_run = 0; m_cnt = 0; m_done = 0; c_idle = 0;
        cmp("R1");
        wr(2'd0, 32'h5);
        idle(1);
        chk("R2 select0 write ignored", 32'(cnt_out), 32'd0);
    endtask

    // R3, R4: left-aligned free-running, tick gating
    task automatic t_left();
        wr(2'd1, 5); wr(2'd2, 2);
        wr(2'd3, mk(1, 1, 1, 0, 0, 0));
        start();
        cmp("R3 start");
        for (int i = 0; i < 12; i++) step("R4");
        idle(4);
        cmp("R3 no tick hold");
    endtask

    // R7, R10: update at boundary then disable
    task automatic t_update();
        step("R4"); step("R4");
        wr(2'd1, 3); wr(2'd2, 1);
        for (int i = 0; i < 10; i++) step("R7");
        stop_ch(1);
        cmp("R10");
    endtask

    // R6: active-low with idle high
    task automatic t_polarity();
        wr(2'd1, 4); wr(2'd2, 1);
        wr(2'd3, mk(1, 1, 0, 1, 0, 0));
        start();
        for (int i = 0; i < 8; i++) step("R6");
        stop_ch(1);
        cmp("R6 idle");
    endtask

    // R5, R7: centre alignment
    task automatic t_center();
        wr(2'd1, 4); wr(2'd2, 1);
        wr(2'd3, mk(1, 1, 1, 0, 1, 0));
        start();
        cmp("R5 start");
        for (int i = 0; i < 16; i++) step("R5");
        wr(2'd1, 2); wr(2'd2, 2);
        for (int i = 0; i < 12; i++) step("R5 R7");
        stop_ch(0);
        cmp("R10");
    endtask

    // R8: burst with repeat 2 left, then repeat 0 centre
    task automatic t_burst();
        wr(2'd1, 3); wr(2'd2, 1);
        wr(2'd3, mk(1, 0, 1, 0, 0, 2));
        start();
        for (int i = 0; i < 12; i++) step("R8");
        chk("R8 done after 3 periods", 32'(done), 32'd1);
        wr(2'd3, mk(1, 0, 1, 1, 1, 0));
        start();
        cmp("R8 restart clears done");
        for (int i = 0; i < 8; i++) step("R8");
        chk("R8 centre burst done", 32'(done), 32'd1);
        chk("R8 idle level", 32'(pwm_out), 32'd1);
    endtask

    // R9: capture
    task automatic t_capture();
        wr(2'd3, mk(1, 2, 1, 1, 0, 0));
        idle(1);
        chk("R9 idle level", 32'(pwm_out), 32'd1);
        @(negedge clk); cap_in = 1'b1; tick = 1'b1;
        repeat (4) @(negedge clk);
        cap_in = 1'b0;
        repeat (3) @(negedge clk);
        tick = 1'b0;
        chk("R9 width all ticks", 32'(cnt_out), 32'd4);
        chk("R9 pwm idle", 32'(pwm_out), 32'd1);
        @(negedge clk); cap_in = 1'b1; tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk); cap_in = 1'b0;
        idle(2);
        chk("R9 width sparse ticks", 32'(cnt_out), 32'd2);
        stop_ch(0);
        chk("R10 capture stop", 32'(cnt_out), 32'd0);
    endtask

    // R11: duty above period and period zero
    task automatic t_full();
        wr(2'd1, 3); wr(2'd2, 5);
        wr(2'd3, mk(1, 1, 1, 0, 0, 0));
        start();
        for (int i = 0; i < 6; i++) step("R11 full duty");
        wr(2'd1, 0); wr(2'd2, 1);
        for (int i = 0; i < 6; i++) step("R11 period zero");
        stop_ch(0);
        cmp("R10");
    endtask

    initial begin
        t_reset();
        t_left();
        t_update();
        t_polarity();
        t_center();
        t_burst();
        t_capture();
        t_full();
        summary();
    end

endmodule